// File: doc/BRIEF.md
# Serial EEPROM Byte and Burst Access Controller

This controller gives a host a small set of registers for reaching a byte-wide serial EEPROM. The host loads an EEPROM address and a data byte, then sets a request bit in the control register to move one byte in either direction. The request bit stays set while the transfer runs and drops by itself when it is done. The EEPROM side is a plain request/acknowledge byte port, so a serial-wire engine or a behavioural model can sit behind it.

A second register starts a burst. In a burst the controller reads the EEPROM as a stream of records and copies the payload bytes into device memory. Each record is a 16-bit destination address, high byte first, followed by one data byte. A record whose address is 0xFFFF ends the burst. The 24-bit memory address has the host-set 9-bit base in its upper bits and the low 15 bits of the record address in its lower bits. Bit 15 of the record address is dropped.

The EEPROM address that a burst starts from depends on what came before. After reset it is 0. After any transfer it is the address that follows the last EEPROM byte touched, and it wraps to 0 past the top of the EEPROM.

The state machine has seven states:
- IDLE
- SINGLE_RD
- SINGLE_WR
- BURST_HI, which fetches the address high byte
- BURST_LO, which fetches the address low byte
- BURST_DATA
- BURST_EMIT

Its transitions are:
- IDLE goes to SINGLE_RD on an accepted read request.
- IDLE goes to SINGLE_WR on an accepted write request with no read bit set.
- IDLE goes to BURST_HI on an accepted burst start.
- SINGLE_RD and SINGLE_WR return to IDLE on acknowledge.
- BURST_HI goes to BURST_LO on acknowledge.
- BURST_LO goes to IDLE on acknowledge when the assembled address is 0xFFFF, and to BURST_DATA on acknowledge otherwise.
- BURST_DATA goes to BURST_EMIT on acknowledge.
- BURST_EMIT goes to BURST_HI after one cycle.

Top module: `eeprom_access_ctrl`

## Requirements
- R1: After reset all three pending flags, the data register, `ee_req` and `mem_we` are 0.
- R2: A host write to the control register (select 0) with bit 1 set reads one EEPROM byte at the address register (select 1) into the data register. `rd_pend` is 1 while this runs and drops to 0 when the byte is valid on `rdata_q`.
- R3: A control write with bit 0 set and bit 1 clear writes the data register (select 2) low byte to the EEPROM at the address register. `wr_pend` drops to 0 on completion.
- R4: A control write with both bits 1 and 0 set performs only the read, and the EEPROM contents are left unchanged. At most one pending flag is ever set.
- R5: A write to the burst register (select 4) with bit 0 set starts a burst. `burst_pend` stays 1 until the terminating record has been read and then clears by itself.
- R6: A burst started after reset, before any single read or write, begins at EEPROM address 0.
- R7: Otherwise a burst begins at the EEPROM address after the last byte accessed, whether by a single transfer or by a previous burst.
- R8: A burst record is three EEPROM bytes: address high, address low, data. A record whose address is 0xFFFF ends the burst and produces no memory write. Every other record produces exactly one memory write with its data byte.
- R9: The memory address of a record is {base register (select 3) bits [8:0], record address bits [14:0]}. Record address bit 15 is ignored.
- R10: Each memory write is presented as a `mem_we` pulse one cycle wide, with `mem_addr` and `mem_wdata` valid in that cycle.
- R11: Host writes to any register while a transfer or burst is running are ignored. This covers request bits, address, data and base.
- R12: The next-address pointer wraps from the top EEPROM address (2^EE_AW-1) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select: 0 control, 1 address, 2 data, 3 base, 4 burst |
| host_wdata | input | HW | Host write data |
| rd_pend | output | 1 | Read request bit, self-clearing |
| wr_pend | output | 1 | Write request bit, self-clearing |
| burst_pend | output | 1 | Burst start bit, self-clearing |
| rdata_q | output | 8 | Data register contents |
| ee_req | output | 1 | EEPROM byte request, held until acknowledged |
| ee_we | output | 1 | EEPROM request is a write |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | EEPROM acknowledge, one cycle |
| ee_rdata | input | 8 | EEPROM read byte, valid with ack |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 8 | Memory write byte |

## Verification
The assertions check the following on every cycle:
- Memory write pulses are single-cycle and occur only inside a burst.
- No two pending flags are ever set together.
- A pending flag rises only from idle.
- An EEPROM write request appears only during a single write.
- The EEPROM request and address are held until acknowledged.

Only the bench scenarios can show the history-dependent start address, the record format and its 0xFFFF terminator, the base joining with bit 15 dropped, pointer wrap, read-over-write priority, and that writes made during a burst really have no effect.

// File: rtl/eectl_pkg.sv
package eectl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SINGLE_RD,
        ST_SINGLE_WR,
        ST_BURST_HI,
        ST_BURST_LO,
        ST_BURST_DATA,
        ST_BURST_EMIT
    } ee_state_e;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_ADDR  = 3'd1;
    localparam logic [2:0] SEL_DATA  = 3'd2;
    localparam logic [2:0] SEL_BASE  = 3'd3;
    localparam logic [2:0] SEL_BURST = 3'd4;

    localparam int unsigned CTL_WR_BIT   = 0;
    localparam int unsigned CTL_RD_BIT   = 1;
    localparam int unsigned BURST_GO_BIT = 0;

    localparam int unsigned BASE_W  = 9;
    localparam int unsigned LOW_W   = 15;
    localparam int unsigned MEM_AW  = BASE_W + LOW_W;
    localparam logic [15:0] REC_END = 16'hFFFF;

endpackage

// File: rtl/eectl_regs.sv
module eectl_regs
    import eectl_pkg::*;
#(
    parameter int unsigned EE_AW = 11,
    parameter int unsigned HW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_we,
    input  logic [2:0]        acc_sel,
    input  logic [HW-1:0]     acc_wdata,
    input  logic              ld_rd,
    input  logic [7:0]        rd_byte,
    output logic [EE_AW-1:0]  addr_q,
    output logic [7:0]        data_q,
    output logic [BASE_W-1:0] base_q
);

    logic unused_wdata;
    assign unused_wdata = ^acc_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            base_q <= '0;
        end else begin
            if (acc_we && acc_sel == SEL_ADDR) begin
                addr_q <= acc_wdata[EE_AW-1:0];
            end
            if (acc_we && acc_sel == SEL_BASE) begin
                base_q <= acc_wdata[BASE_W-1:0];
            end
            if (ld_rd) begin
                data_q <= rd_byte;
            end else if (acc_we && acc_sel == SEL_DATA) begin
                data_q <= acc_wdata[7:0];
            end
        end
    end

endmodule

// File: rtl/eectl_fsm.sv
module eectl_fsm
    import eectl_pkg::*;
#(
    parameter int unsigned EE_AW = 11,
    parameter int unsigned HW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_we,
    input  logic [2:0]        acc_sel,
    input  logic [HW-1:0]     acc_wdata,
    input  logic [EE_AW-1:0]  addr_q,
    input  logic [7:0]        data_q,
    input  logic [BASE_W-1:0] base_q,
    input  logic              ee_ack,
    input  logic [7:0]        ee_rdata,
    output ee_state_e         st_q,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata,
    output logic              ld_rd,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    localparam logic [EE_AW-1:0] PTR_STEP = EE_AW'(1);

    ee_state_e        st_d;
    logic [EE_AW-1:0] ptr_q;
    logic [7:0]       rec_hi_q;
    logic [7:0]       rec_lo_q;
    logic [7:0]       rec_dat_q;
    logic             go_rd;
    logic             go_wr;
    logic             go_burst;
    logic             unused_bits;

    assign unused_bits = ^{acc_wdata, rec_hi_q[7]};

    assign go_rd    = acc_we && acc_sel == SEL_CTRL  && acc_wdata[CTL_RD_BIT];
    assign go_wr    = acc_we && acc_sel == SEL_CTRL  && acc_wdata[CTL_WR_BIT];
    assign go_burst = acc_we && acc_sel == SEL_BURST && acc_wdata[BURST_GO_BIT];

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (go_rd)         st_d = ST_SINGLE_RD;
                else if (go_wr)    st_d = ST_SINGLE_WR;
                else if (go_burst) st_d = ST_BURST_HI;
            end
            ST_SINGLE_RD,
            ST_SINGLE_WR: begin
                if (ee_ack) st_d = ST_IDLE;
            end
            ST_BURST_HI: begin
                if (ee_ack) st_d = ST_BURST_LO;
            end
            ST_BURST_LO: begin
                if (ee_ack) begin
                    st_d = ({rec_hi_q, ee_rdata} == REC_END) ? ST_IDLE
                                                             : ST_BURST_DATA;
                end
            end
            ST_BURST_DATA: begin
                if (ee_ack) st_d = ST_BURST_EMIT;
            end
            ST_BURST_EMIT: st_d = ST_BURST_HI;
            default:       st_d = ST_IDLE;
        endcase
    end

    // state register with pointer and record capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            ptr_q     <= '0;
            rec_hi_q  <= '0;
            rec_lo_q  <= '0;
            rec_dat_q <= '0;
        end else begin
            st_q <= st_d;
            if (ee_ack) begin
                unique case (st_q)
                    ST_SINGLE_RD,
                    ST_SINGLE_WR: ptr_q <= addr_q + PTR_STEP;
                    ST_BURST_HI: begin
                        rec_hi_q <= ee_rdata;
                        ptr_q    <= ptr_q + PTR_STEP;
                    end
                    ST_BURST_LO: begin
                        rec_lo_q <= ee_rdata;
                        ptr_q    <= ptr_q + PTR_STEP;
                    end
                    ST_BURST_DATA: begin
                        rec_dat_q <= ee_rdata;
                        ptr_q     <= ptr_q + PTR_STEP;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        ee_req    = 1'b0;
        ee_we     = 1'b0;
        ee_addr   = ptr_q;
        ee_wdata  = data_q;
        ld_rd     = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {base_q, rec_hi_q[6:0], rec_lo_q};
        mem_wdata = rec_dat_q;
        unique case (st_q)
            ST_IDLE: ;
            ST_SINGLE_RD: begin
                ee_req  = 1'b1;
                ee_addr = addr_q;
                ld_rd   = ee_ack;
            end
            ST_SINGLE_WR: begin
                ee_req  = 1'b1;
                ee_we   = 1'b1;
                ee_addr = addr_q;
            end
            ST_BURST_HI,
            ST_BURST_LO,
            ST_BURST_DATA: ee_req = 1'b1;
            ST_BURST_EMIT: mem_we = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/eeprom_access_ctrl.sv
module eeprom_access_ctrl
    import eectl_pkg::*;
#(
    parameter int unsigned EE_AW = 11,
    parameter int unsigned HW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [2:0]       host_sel,
    input  logic [HW-1:0]    host_wdata,
    output logic             rd_pend,
    output logic             wr_pend,
    output logic             burst_pend,
    output logic [7:0]       rdata_q,
    output logic             ee_req,
    output logic             ee_we,
    output logic [EE_AW-1:0] ee_addr,
    output logic [7:0]       ee_wdata,
    input  logic             ee_ack,
    input  logic [7:0]       ee_rdata,
    output logic             mem_we,
    output logic [23:0]      mem_addr,
    output logic [7:0]       mem_wdata
);

    ee_state_e        st;
    logic             acc_we;
    logic             ld_rd;
    logic [EE_AW-1:0] addr_q;
    logic [BASE_W-1:0] base_q;

    // host writes only land while idle
    assign acc_we = host_we && (st == ST_IDLE);

    assign rd_pend    = (st == ST_SINGLE_RD);
    assign wr_pend    = (st == ST_SINGLE_WR);
    assign burst_pend = (st == ST_BURST_HI) || (st == ST_BURST_LO) ||
                        (st == ST_BURST_DATA) || (st == ST_BURST_EMIT);

    eectl_regs #(.EE_AW(EE_AW), .HW(HW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_we    (acc_we),
        .acc_sel   (host_sel),
        .acc_wdata (host_wdata),
        .ld_rd     (ld_rd),
        .rd_byte   (ee_rdata),
        .addr_q    (addr_q),
        .data_q    (rdata_q),
        .base_q    (base_q)
    );

    eectl_fsm #(.EE_AW(EE_AW), .HW(HW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_we    (acc_we),
        .acc_sel   (host_sel),
        .acc_wdata (host_wdata),
        .addr_q    (addr_q),
        .data_q    (rdata_q),
        .base_q    (base_q),
        .ee_ack    (ee_ack),
        .ee_rdata  (ee_rdata),
        .st_q      (st),
        .ee_req    (ee_req),
        .ee_we     (ee_we),
        .ee_addr   (ee_addr),
        .ee_wdata  (ee_wdata),
        .ld_rd     (ld_rd),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/eectl_chk.sv
module eectl_chk #(
    parameter int unsigned EE_AW = 11,
    parameter int unsigned HW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_we,
    input logic [2:0]       host_sel,
    input logic [HW-1:0]    host_wdata,
    input logic             rd_pend,
    input logic             wr_pend,
    input logic             burst_pend,
    input logic [7:0]       rdata_q,
    input logic             ee_req,
    input logic             ee_we,
    input logic [EE_AW-1:0] ee_addr,
    input logic [7:0]       ee_wdata,
    input logic             ee_ack,
    input logic [7:0]       ee_rdata,
    input logic             mem_we,
    input logic [23:0]      mem_addr,
    input logic [7:0]       mem_wdata
);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r10_only_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> burst_pend);

    a_r4_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_pend, wr_pend, burst_pend}));

    a_r11_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_pend) || $rose(wr_pend) || $rose(burst_pend))
        |-> $past(!(rd_pend || wr_pend || burst_pend)));

    a_r3_write_only_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && ee_we) |-> wr_pend);

    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr)));

endmodule

bind eeprom_access_ctrl eectl_chk #(.EE_AW(EE_AW), .HW(HW)) u_chk (.*);

// File: tb/eeprom_access_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_access_ctrl_bench;

    localparam int EE_AW = 11;
    localparam int HW    = 16;
    localparam int DEPTH = 1 << EE_AW;

    typedef struct packed {
        logic [23:0] a;
        logic [7:0]  d;
    } mw_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_we = 1'b0;
    logic [2:0]       host_sel = '0;
    logic [HW-1:0]    host_wdata = '0;
    logic             rd_pend, wr_pend, burst_pend;
    logic [7:0]       rdata_q;
    logic             ee_req, ee_we;
    logic [EE_AW-1:0] ee_addr;
    logic [7:0]       ee_wdata;
    logic             ee_ack = 1'b0;
    logic [7:0]       ee_rdata = '0;
    logic             mem_we;
    logic [23:0]      mem_addr;
    logic [7:0]       mem_wdata;

    logic [7:0] emem [0:DEPTH-1];
    mw_t        exp_q[$];
    logic [8:0] base_cur = '0;
    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    eeprom_access_ctrl #(.EE_AW(EE_AW), .HW(HW)) u_eeprom_access_ctrl (.*);

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] sel, input logic [HW-1:0] val);
        @(negedge clk);
        host_we    = 1'b1;
        host_sel   = sel;
        host_wdata = val;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic wait_idle();
        while (rd_pend || wr_pend || burst_pend) @(negedge clk);
    endtask

    task automatic put_rec(input int p, input logic [15:0] a, input logic [7:0] d);
        emem[p]   = a[15:8];
        emem[p+1] = a[7:0];
        emem[p+2] = d;
    endtask

    task automatic put_end(input int p);
        emem[p]   = 8'hFF;
        emem[p+1] = 8'hFF;
    endtask

    task automatic expect_mw(input logic [15:0] a, input logic [7:0] d);
        mw_t e;
        e.a = {base_cur, a[14:0]};
        e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic set_base(input logic [8:0] b);
        base_cur = b;
        hwrite(3'd3, HW'(b));
    endtask

    // EEPROM behavioural model: acknowledges after a short latency
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (ee_ack) begin
                ee_ack = 1'b0;
            end else if (ee_req) begin
                if (lat == 2) begin
                    ee_rdata = emem[ee_addr];
                    if (ee_we) emem[ee_addr] = ee_wdata;
                    ee_ack = 1'b1;
                    lat = 0;
                end else begin
                    lat++;
                end
            end
        end
    end

    // scoreboard monitor
    initial begin
        mw_t e;
        bit  prev_we;
        prev_we = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_we) begin
                chk(!prev_we, "R10 strobe longer than one cycle", 32'(prev_we), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected memory write", mem_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(mem_addr == e.a, "R9 memory address", mem_addr, e.a);
                    chk(mem_wdata == e.d, "R8 memory data", mem_wdata, e.d);
                end
            end
            prev_we = rst_n && mem_we;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) emem[i] = 8'(i * 7 + 3);

        // image at 0: two records then terminator (pointer ends at 8)
        put_rec(0, 16'h0012, 8'hA5);
        put_rec(3, 16'h8034, 8'h5A);
        put_end(6);
        // image at 8: top low address is not a terminator
        put_rec(8, 16'h7FFF, 8'h11);
        put_end(11);
        // image at 0x102 and 0x107
        put_rec(12'h102, 16'h0200, 8'h77);
        put_end(12'h105);
        put_rec(12'h107, 16'h0001, 8'h99);
        put_end(12'h10A);

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!rd_pend && !wr_pend && !burst_pend, "R1 pending flags",
            {rd_pend, wr_pend, burst_pend}, 0);
        chk(rdata_q == 8'h00, "R1 data register", rdata_q, 0);
        chk(!ee_req && !mem_we, "R1 idle strobes", {ee_req, mem_we}, 0);
        rst_n = 1'b1;

        // R6 burst from address 0, R9 base join with bit 15 dropped
        set_base(9'h155);
        expect_mw(16'h0012, 8'hA5);
        expect_mw(16'h8034, 8'h5A);
        hwrite(3'd4, 16'h0001);
        chk(burst_pend, "R5 burst flag set", burst_pend, 1);
        wait_idle();
        chk(!burst_pend, "R5 burst flag clears", burst_pend, 0);
        chk(exp_q.size() == 0, "R6 burst from zero emitted all records", exp_q.size(), 0);

        // R7 continuation after burst, R8 0x7FFF is an ordinary record
        set_base(9'h0A3);
        expect_mw(16'h7FFF, 8'h11);
        hwrite(3'd4, 16'h0001);
        wait_idle();
        chk(exp_q.size() == 0, "R7 burst continues after previous burst", exp_q.size(), 0);

        // R2 single read
        hwrite(3'd1, 16'h0100);
        hwrite(3'd0, 16'h0002);
        chk(rd_pend, "R2 read flag set", rd_pend, 1);
        wait_idle();
        chk(rdata_q == emem[12'h100], "R2 read data", rdata_q, emem[12'h100]);

        // R3 single write
        hwrite(3'd1, 16'h0101);
        hwrite(3'd2, 16'h003C);
        hwrite(3'd0, 16'h0001);
        chk(wr_pend, "R3 write flag set", wr_pend, 1);
        wait_idle();
        chk(emem[12'h101] == 8'h3C, "R3 EEPROM written", emem[12'h101], 8'h3C);

        // R7 burst after single write starts at 0x102
        expect_mw(16'h0200, 8'h77);
        hwrite(3'd4, 16'h0001);
        wait_idle();
        chk(exp_q.size() == 0, "R7 burst continues after single write", exp_q.size(), 0);

        // R11 writes during burst are ignored
        expect_mw(16'h0001, 8'h99);
        hwrite(3'd4, 16'h0001);
        hwrite(3'd1, 16'h0050);
        hwrite(3'd2, 16'h00DD);
        hwrite(3'd3, 16'h01FF);
        hwrite(3'd0, 16'h0002);
        chk(!rd_pend && burst_pend, "R11 read request ignored while busy",
            {rd_pend, burst_pend}, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R11 burst unaffected", exp_q.size(), 0);
        chk(rdata_q == 8'h3C, "R11 data register unchanged", rdata_q, 8'h3C);
        hwrite(3'd0, 16'h0002);
        wait_idle();
        chk(rdata_q == 8'h3C, "R11 address register unchanged", rdata_q, 8'h3C);

        // R12 wrap: read top address, burst starts at 0 (base still 0x0A3)
        hwrite(3'd1, 16'(DEPTH - 1));
        hwrite(3'd0, 16'h0002);
        wait_idle();
        chk(rdata_q == emem[DEPTH-1], "R12 top address read", rdata_q, emem[DEPTH-1]);
        expect_mw(16'h0012, 8'hA5);
        expect_mw(16'h8034, 8'h5A);
        hwrite(3'd4, 16'h0001);
        wait_idle();
        chk(exp_q.size() == 0, "R12 pointer wrapped to zero", exp_q.size(), 0);

        // R4 both request bits: read only
        v = emem[12'h300];
        hwrite(3'd1, 16'h0300);
        hwrite(3'd2, 16'h00EE);
        hwrite(3'd0, 16'h0003);
        chk(rd_pend && !wr_pend, "R4 read takes priority", {rd_pend, wr_pend}, 2);
        wait_idle();
        chk(rdata_q == v, "R4 read data", rdata_q, v);
        chk(emem[12'h300] == v, "R4 EEPROM unchanged", emem[12'h300], v);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule